// File: doc/BRIEF.md
# Pipelined Counter Word Decoder

A fast free-running counter can be built as a chain of divide-by-two cells, each passing its carry to the next as a one-clock pulse. Every gate then sits next to a flip-flop, so the counter runs at a high clock rate. The cost is that each higher bit lags by a few clocks, and a sampled word is therefore not a plain binary count. This block turns such a raw word back into the true binary value in hardware, so software does not have to apply the fix.

The correction walks the bit positions upward from position 1. At each position the lower bits, already corrected, are read as an unsigned number. If that number is less than the position index, the bit at that position is inverted. A parameter sets how many register stages are spread evenly along this chain of steps. The result strobe follows the input strobe by exactly that many cycles. The width parameter covers counters of up to 32 bits and more.

Top module: `pcw_decode`

## Requirements
- R1: For each accepted word, `data_o` equals the word produced by running correction steps for positions k = 1 to WIDTH-1 in ascending order, with each step reading the word as already modified by all lower steps.
- R2: At step k, bit k is inverted exactly when the unsigned value of bits [k-1:0] of the working word is smaller than k. Otherwise bit k is kept.
- R3: Bit 0 of `data_o` always equals bit 0 of the matching input word.
- R4: `valid_o` equals `valid_i` delayed by exactly PIPE_STAGES clock cycles (0 to WIDTH-1). The `data_o` present with it belongs to the word that was strobed in that earlier cycle.
- R5: With PIPE_STAGES > 0, `data_o` changes only in cycles where `valid_o` is 1. It holds its value while no result leaves the block, whatever `data_i` does.
- R6: While `rst_ni` is 0, `valid_o` and `data_o` are 0 (PIPE_STAGES > 0).
- R7: Words strobed in consecutive cycles each give exactly one result, in input order, with no bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Raw word strobe |
| data_i | input | WIDTH | Raw counter word |
| valid_o | output | 1 | Result strobe |
| data_o | output | WIDTH | Binary count |

## Verification
The hardest case to reach is a chain of corrections, where flipping one bit changes the lower value seen by a later step and so triggers or suppresses another flip far up the word. An example is raw 3, which is fixed at positions 4 and 20. The table holds hand-worked words that force such chains at the full 32-bit width. All 64 words of a 6-bit instance are streamed back to back, so every ordering of flips at that width appears. Random 32-bit words follow, streamed without gaps.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  // true when a register stage follows correction step k
  function automatic bit stage_cut(input int k, input int lat, input int steps);
    return ((k * lat) / steps) != (((k - 1) * lat) / steps);
  endfunction
endpackage

// File: rtl/pcw_step.sv
module pcw_step #(
  parameter int WIDTH = 32,
  parameter int K     = 1
) (
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] word_o
);
  localparam logic [K-1:0] K_VAL = K[K-1:0];

  always_comb begin
    word_o = word_i;
    if (word_i[K-1:0] < K_VAL) word_o[K] = ~word_i[K];
  end
endmodule

// File: rtl/pcw_stage.sv
module pcw_stage #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= data_i;
    end
  end

  assert_valid_advance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_advance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
endmodule

// File: rtl/pcw_decode.sv
module pcw_decode #(
  parameter int WIDTH       = 32,
  parameter int PIPE_STAGES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o
);
  localparam int STEPS = WIDTH - 1;

  if (WIDTH < 2) begin : g_bad_width
    $error("pcw_decode: WIDTH must be at least 2");
  end
  if (PIPE_STAGES < 0 || PIPE_STAGES > STEPS) begin : g_bad_lat
    $error("pcw_decode: PIPE_STAGES must lie in 0..WIDTH-1");
  end

  logic [WIDTH-1:0] wrd [WIDTH];
  logic             vld [WIDTH];

  assign wrd[0] = data_i;
  assign vld[0] = valid_i;

  for (genvar k = 1; k < WIDTH; k++) begin : g_step
    logic [WIDTH-1:0] fixed;

    pcw_step #(.WIDTH(WIDTH), .K(k)) u_step (
      .word_i (wrd[k-1]),
      .word_o (fixed)
    );

    if (pcw_pkg::stage_cut(k, PIPE_STAGES, STEPS)) begin : g_reg
      pcw_stage #(.WIDTH(WIDTH)) u_stage (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .valid_i (vld[k-1]),
        .data_i  (fixed),
        .valid_o (vld[k]),
        .data_o  (wrd[k])
      );
    end else begin : g_wire
      assign wrd[k] = fixed;
      assign vld[k] = vld[k-1];
    end
  end

  assign data_o  = wrd[STEPS];
  assign valid_o = vld[STEPS];

  // independent delay line for strobe and bit 0
  if (PIPE_STAGES > 0) begin : g_chk
    logic [PIPE_STAGES-1:0] vld_sh;
    logic [PIPE_STAGES-1:0] b0_sh;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_sh <= '0;
        b0_sh  <= '0;
      end else begin
        vld_sh[0] <= valid_i;
        b0_sh[0]  <= data_i[0];
        for (int i = 1; i < PIPE_STAGES; i++) begin
          vld_sh[i] <= vld_sh[i-1];
          b0_sh[i]  <= b0_sh[i-1];
        end
      end
    end

    assert_valid_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o == vld_sh[PIPE_STAGES-1]);
    assert_bit0_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> data_o[0] == b0_sh[PIPE_STAGES-1]);
  end
endmodule

// File: tb/pcw_decode_tb.sv
module pcw_decode_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W32 = 32;
  localparam int L32 = 4;
  localparam int W6  = 6;
  localparam int L6  = 2;
  localparam int NTAB = 6;

  // raw word, expected binary count (hand-worked for 32 bits)
  localparam logic [31:0] TAB_RAW [NTAB] = '{32'h0000_0000, 32'h0000_0001, 32'h0000_0002,
                                             32'h0000_0003, 32'h8000_0000, 32'hFFFF_FFFF};
  localparam logic [31:0] TAB_EXP [NTAB] = '{32'h0000_080A, 32'h0000_0045, 32'h0000_0024,
                                             32'h0010_0013, 32'h8000_080A, 32'hFFFF_FFFF};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v32_i = 1'b0, v6_i = 1'b0;
  logic [W32-1:0] d32_i = '0;
  logic [W6-1:0]  d6_i = '0;
  logic v32_o, v6_o;
  logic [W32-1:0] d32_o;
  logic [W6-1:0]  d6_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] q32 [512];
  logic [31:0] raw32 [512];
  int wr32 = 0, rd32 = 0;
  logic [5:0] q6 [128];
  int wr6 = 0, rd6 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcw_decode #(.WIDTH(W32), .PIPE_STAGES(L32)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v32_i), .data_i(d32_i),
    .valid_o(v32_o), .data_o(d32_o));

  pcw_decode #(.WIDTH(W6), .PIPE_STAGES(L6)) dut_small_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v6_i), .data_i(d6_i),
    .valid_o(v6_o), .data_o(d6_o));

  function automatic logic [31:0] model(input logic [31:0] y_in, input int n);
    logic [63:0] y;
    logic [63:0] m;
    y = {32'h0, y_in};
    for (int k = 1; k < n; k++) begin
      m = (64'd1 << k) - 64'd1;
      if ((y & m) < 64'(k)) y = y ^ (64'd1 << k);
    end
    return y[31:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive32(input bit v, input logic [31:0] d);
    @(negedge clk);
    v32_i = v;
    d32_i = d;
    if (v) begin
      q32[wr32 % 512]   = model(d, W32);
      raw32[wr32 % 512] = d;
      wr32++;
    end
  endtask

  // output monitors: R1, R2, R3, R7
  always @(negedge clk) begin
    if (rst_n && v32_o) begin
      if (rd32 >= wr32) check(1'b0, "R7 extra result", d32_o, 32'h0);
      else begin
        check(d32_o == q32[rd32 % 512], "R1 R2 decode32", d32_o, q32[rd32 % 512]);
        check(d32_o[0] == raw32[rd32 % 512][0], "R3 bit0", {31'h0, d32_o[0]},
              {31'h0, raw32[rd32 % 512][0]});
        rd32++;
      end
    end
    if (rst_n && v6_o) begin
      if (rd6 >= wr6) check(1'b0, "R7 extra result6", {26'h0, d6_o}, 32'h0);
      else begin
        check(d6_o == q6[rd6 % 128], "R1 decode6", {26'h0, d6_o}, {26'h0, q6[rd6 % 128]});
        rd6++;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] held;
    int lat;
    // R6 reset state
    repeat (3) @(negedge clk);
    check(v32_o == 1'b0, "R6 valid in reset", {31'h0, v32_o}, 32'h0);
    check(d32_o == '0, "R6 data in reset", d32_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk, R1 R2 (also verifies bench model)
    for (int i = 0; i < NTAB; i++) begin
      check(model(TAB_RAW[i], W32) == TAB_EXP[i], "R2 table model", model(TAB_RAW[i], W32),
            TAB_EXP[i]);
      drive32(1'b1, TAB_RAW[i]);
    end
    drive32(1'b0, '0);
    repeat (L32 + 2) @(negedge clk);
    check(rd32 == wr32, "R7 table count", 32'(rd32), 32'(wr32));

    // R4 latency
    drive32(1'b1, 32'h0000_0003);
    lat = 0;
    @(negedge clk);
    v32_i = 1'b0;
    lat = 1;
    while (!v32_o && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check(lat == L32, "R4 latency", 32'(lat), 32'(L32));
    repeat (2) @(negedge clk);

    // R5 hold while idle
    held = d32_o;
    for (int i = 0; i < 8; i++) begin
      drive32(1'b0, $urandom);
      check(d32_o == held, "R5 hold", d32_o, held);
      check(v32_o == 1'b0, "R5 no strobe", {31'h0, v32_o}, 32'h0);
    end

    // exhaustive 6-bit streaming, R1 R7
    for (int y = 0; y < 64; y++) begin
      @(negedge clk);
      v6_i = 1'b1;
      d6_i = 6'(y);
      q6[wr6 % 128] = 6'(model(32'(y), W6));
      wr6++;
    end
    @(negedge clk);
    v6_i = 1'b0;
    repeat (L6 + 2) @(negedge clk);
    check(rd6 == 64, "R7 stream6 count", 32'(rd6), 32'd64);

    // random 32-bit streaming, R1 R7
    for (int i = 0; i < 300; i++) drive32(1'b1, $urandom);
    drive32(1'b0, '0);
    repeat (L32 + 2) @(negedge clk);
    check(rd32 == wr32, "R7 random count", 32'(rd32), 32'(wr32));

    // R6 reset mid-stream
    for (int i = 0; i < 3; i++) drive32(1'b1, $urandom);
    @(negedge clk);
    rst_n = 1'b0;
    v32_i = 1'b0;
    #1;
    check(v32_o == 1'b0, "R6 valid after reset", {31'h0, v32_o}, 32'h0);
    check(d32_o == '0, "R6 data after reset", d32_o, 32'h0);
    rd32 = wr32;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive32(1'b1, 32'h0000_0001);
    drive32(1'b0, '0);
    repeat (L32 + 2) @(negedge clk);
    check(rd32 == wr32, "R7 after reset count", 32'(rd32), 32'(wr32));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule